// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block turns a fast reference clock into the two timing strobes a UART needs. One is an oversample strobe that the receiver uses to sample the line. The other is a bit strobe that paces the transmitter and marks receive sample points. The reference clock passes through two cascaded counters. A small prescaler comes first and brings the reference down to roughly 12 MHz. A baud divisor follows, and its output is the oversample strobe. A third counter then groups thirteen oversample strobes into one bit period, where sixteen is the more common choice.

Software programs the block through a single configuration word that carries both counter limits, each stored as its value minus one. A written word does not take effect at once. It waits in a holding register and moves into the active counters only at the next bit boundary, so no bit period ever comes out shortened or stretched. While such an update is waiting, a busy flag is high, and software polls that flag before it writes again. The receiver can pulse an alignment input when it detects a start-bit edge. The bit strobe then lands near the middle of the start bit.

With a 12 MHz prescaled clock and thirteen oversamples per bit, the ten-bit divisor covers rates from about 900 baud up to 921600 baud.

Top module: `baud_tickgen`

## Requirements
- R1: After reset, the readback word is zero, the busy flag is low, and the active limits are zero. The oversample strobe therefore fires on every clock and the bit strobe fires every 13 clocks.
- R2: The readback word returns the most recently written prescaler field in bits [19:16] and divisor field in bits [9:0], from the cycle after the write. Every other bit reads as zero, whatever was written to it.
- R3: With active prescaler field P and divisor field D, the oversample strobe is a single-clock pulse that repeats every (P+1)*(D+1) clocks.
- R4: The bit strobe is high only in a cycle where the oversample strobe is also high, and it fires on every 13th oversample strobe.
- R5: A write raises the busy flag from the next cycle. The written limits do not touch the counters before the next bit boundary, so the bit period that is running completes at its old length.
- R6: At the first bit strobe after a write, the held limits become active and all counters restart from zero. The busy flag is low from the following cycle, and the first new bit period lasts exactly 13*(P+1)*(D+1) clocks.
- R7: A second write made while the busy flag is high replaces the held value. Only the last written limits take effect at the boundary.
- R8: A pulse on the alignment input clears the prescaler and divisor counters and sets the oversample phase to 6. The next bit strobe comes exactly 7*(P+1)*(D+1) clocks after the cycle of the pulse, and later strobes are 13*(P+1)*(D+1) clocks apart. No bit strobe occurs in the cycle right after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: prescaler-1 in [19:16], divisor-1 in [9:0] |
| cfg_rdata | output | 32 | Readback of the last written limits, unused bits zero |
| upd_busy | output | 1 | High while a written update waits for a bit boundary |
| rx_align | input | 1 | One-cycle pulse from the receiver at a start-bit edge |
| os_tick | output | 1 | Oversample strobe, one clock wide |
| bit_tick | output | 1 | Bit strobe, every 13th oversample strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit prescaler field at bit 16, a 10-bit divisor field at bit 0, and 13 oversamples per bit. Small limit values (oversample periods of 1, 3 and 6 clocks) put dozens of bit periods within a short run. They are used to time boundary updates, back-to-back writes and realignment to the exact clock. Writing all ones reaches the largest divisor chain, a 16384-clock oversample period. The same write exercises masking of the unused bits.

// File: rtl/baud_pkg.sv
package baud_pkg;

   localparam int unsigned MAX_REG_W = 64;

   // Mask with ones over [lsb +: w], built bit by bit
   function automatic logic [MAX_REG_W-1:0] field_mask(input int unsigned lsb,
                                                       input int unsigned w);
      logic [MAX_REG_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < MAX_REG_W; i++) begin
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      end
      return m;
   endfunction

   // Counter control for the shared modulo counter
   typedef struct packed {
      logic en;
      logic clr;
      logic ld;
   } cnt_ctl_t;

endpackage

// File: rtl/baud_modcnt.sv
module baud_modcnt #(
   parameter int unsigned W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  baud_pkg::cnt_ctl_t   ctl,
   input  logic [W-1:0]         ld_val,
   input  logic [W-1:0]         lim,
   output logic [W-1:0]         cnt,
   output logic                 at_lim
);

   assign at_lim = (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ctl.clr) begin
         cnt <= '0;
      end else if (ctl.ld) begin
         cnt <= ld_val;
      end else if (ctl.en) begin
         if (at_lim) cnt <= '0;
         else        cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned PRE_W   = 4,
   parameter int unsigned PRE_LSB = 16,
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned DIV_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              boundary,
   output logic [REG_W-1:0]  rdata,
   output logic              busy,
   output logic [PRE_W-1:0]  act_pre,
   output logic [DIV_W-1:0]  act_div
);

   logic [PRE_W-1:0] hold_pre;
   logic [DIV_W-1:0] hold_div;
   logic             promote;

   // A waiting update moves into the counters only at a bit boundary
   assign promote = boundary && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_pre <= '0;
         hold_div <= '0;
         act_pre  <= '0;
         act_div  <= '0;
         busy     <= 1'b0;
      end else begin
         if (promote) begin
            act_pre <= hold_pre;
            act_div <= hold_div;
         end
         if (wr) begin
            hold_pre <= wdata[PRE_LSB +: PRE_W];
            hold_div <= wdata[DIV_LSB +: DIV_W];
            busy     <= 1'b1;
         end else if (promote) begin
            busy     <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      rdata[PRE_LSB +: PRE_W] = hold_pre;
      rdata[DIV_LSB +: DIV_W] = hold_div;
   end

endmodule

// File: rtl/baud_tickgen.sv
module baud_tickgen #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned PRE_W    = 4,
   parameter int unsigned PRE_LSB  = 16,
   parameter int unsigned DIV_W    = 10,
   parameter int unsigned DIV_LSB  = 0,
   parameter int unsigned OS_RATIO = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic              upd_busy,
   input  logic              rx_align,
   output logic              os_tick,
   output logic              bit_tick
);
   import baud_pkg::*;

   localparam int unsigned OS_W   = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
   localparam int unsigned OS_MID = OS_RATIO / 2;

   // Elaboration-time parameter checks
   if (REG_W > MAX_REG_W) begin : g_bad_regw
      $error("REG_W exceeds the supported maximum");
   end
   if (PRE_LSB + PRE_W > REG_W || DIV_LSB + DIV_W > REG_W) begin : g_bad_fit
      $error("a limit field does not fit in the word");
   end
   if (!(DIV_LSB + DIV_W <= PRE_LSB || PRE_LSB + PRE_W <= DIV_LSB)) begin : g_bad_overlap
      $error("limit fields overlap");
   end
   if (OS_RATIO < 1 || PRE_W < 1 || DIV_W < 1) begin : g_bad_size
      $error("counter sizes must be at least one");
   end

   logic [PRE_W-1:0] act_pre, pre_cnt;
   logic [DIV_W-1:0] act_div, div_cnt;
   logic             pre_wrap, div_wrap, os_wrap;
   cnt_ctl_t         pre_ctl, div_ctl;

   baud_cfg_reg #(
      .REG_W(REG_W), .PRE_W(PRE_W), .PRE_LSB(PRE_LSB),
      .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .wdata    (cfg_wdata),
      .boundary (bit_tick),
      .rdata    (cfg_rdata),
      .busy     (upd_busy),
      .act_pre  (act_pre),
      .act_div  (act_div)
   );

   // Stage 1: prescaler, counts every reference clock
   always_comb begin
      pre_ctl.en  = 1'b1;
      pre_ctl.clr = rx_align || bit_tick;
      pre_ctl.ld  = 1'b0;
   end

   baud_modcnt #(.W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (pre_ctl),
      .ld_val ('0),
      .lim    (act_pre),
      .cnt    (pre_cnt),
      .at_lim (pre_wrap)
   );

   // Stage 2: baud divisor, counts prescaler wraps
   always_comb begin
      div_ctl.en  = pre_wrap;
      div_ctl.clr = rx_align || bit_tick;
      div_ctl.ld  = 1'b0;
   end

   baud_modcnt #(.W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (div_ctl),
      .ld_val ('0),
      .lim    (act_div),
      .cnt    (div_cnt),
      .at_lim (div_wrap)
   );

   assign os_tick = pre_wrap && div_wrap;

   // Stage 3: oversample grouping, present only when more than one per bit
   if (OS_RATIO > 1) begin : g_os_cnt
      logic [OS_W-1:0] os_cnt;
      cnt_ctl_t        os_ctl;

      always_comb begin
         os_ctl.en  = os_tick;
         os_ctl.clr = 1'b0;
         os_ctl.ld  = rx_align;
      end

      baud_modcnt #(.W(OS_W)) u_os (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl    (os_ctl),
         .ld_val (OS_W'(OS_MID)),
         .lim    (OS_W'(OS_RATIO - 1)),
         .cnt    (os_cnt),
         .at_lim (os_wrap)
      );
   end else begin : g_os_none
      assign os_wrap = 1'b1;
   end

   assign bit_tick = os_tick && os_wrap;

endmodule

// File: rtl/baud_tickgen_chk.sv
module baud_tickgen_chk #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned PRE_W    = 4,
   parameter int unsigned PRE_LSB  = 16,
   parameter int unsigned DIV_W    = 10,
   parameter int unsigned DIV_LSB  = 0,
   parameter int unsigned OS_RATIO = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic              upd_busy,
   input logic              rx_align,
   input logic              os_tick,
   input logic              bit_tick
);
   import baud_pkg::*;

   localparam logic [REG_W-1:0] USED =
      REG_W'(field_mask(PRE_LSB, PRE_W) | field_mask(DIV_LSB, DIV_W));

   // R2: unused readback bits are zero
   a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~USED) == '0);

   // R2: readback changes only through a write
   a_r2_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_rdata));

   // R4: bit strobe coincides with an oversample strobe
   a_r4_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick);

   // R5: a write raises busy
   a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> upd_busy);

   // R6: busy drops only after a bit boundary
   a_r6_busy_clear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_busy) |-> $past(bit_tick));

   // R8: no bit strobe right after an alignment pulse
   if (OS_RATIO > 2) begin : g_align
      a_r8_no_bit_after_align: assert property (@(posedge clk) disable iff (!rst_n)
         rx_align |=> !bit_tick);
   end

endmodule

bind baud_tickgen baud_tickgen_chk #(
   .REG_W(REG_W), .PRE_W(PRE_W), .PRE_LSB(PRE_LSB),
   .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .OS_RATIO(OS_RATIO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_rdata (cfg_rdata),
   .upd_busy  (upd_busy),
   .rx_align  (rx_align),
   .os_tick   (os_tick),
   .bit_tick  (bit_tick)
);

// File: tb/tb_baud_tickgen.sv
`timescale 1ns/1ps
module tb_baud_tickgen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        upd_busy;
   logic        rx_align = 1'b0;
   logic        os_tick;
   logic        bit_tick;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   baud_tickgen dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .upd_busy(upd_busy), .rx_align(rx_align),
      .os_tick(os_tick), .bit_tick(bit_tick)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_os(output int t);
      @(negedge clk);
      while (!os_tick) @(negedge clk);
      t = cyc;
   endtask

   task automatic wait_bit(output int t);
      @(negedge clk);
      while (!bit_tick) @(negedge clk);
      t = cyc;
   endtask

   task automatic write_cfg(input logic [31:0] v);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic t_reset();
      int a, b;
      check(cfg_rdata == 32'h0, "R1 readback", cfg_rdata, 0);
      check(upd_busy == 1'b0, "R1 busy", upd_busy, 0);
      wait_os(a); wait_os(b);
      check(b - a == 1, "R1 R3 os period", b - a, 1);
      wait_bit(a); wait_bit(b);
      check(b - a == 13, "R1 R4 bit period", b - a, 13);
   endtask

   task automatic t_update();
      int tp, t1, t2, a, b;
      wait_bit(tp);
      @(negedge clk);
      write_cfg(32'h0001_0002);           // P=1, D=2 -> 6 clocks per os
      check(cfg_rdata == 32'h0001_0002, "R2 readback", cfg_rdata, 32'h0001_0002);
      check(upd_busy == 1'b1, "R5 busy set", upd_busy, 1);
      wait_bit(t1);
      check(t1 - tp == 13, "R5 old period kept", t1 - tp, 13);
      @(negedge clk);
      check(upd_busy == 1'b0, "R6 busy cleared", upd_busy, 0);
      wait_bit(t2);
      check(t2 - t1 == 78, "R6 first new period", t2 - t1, 78);
      wait_os(a); wait_os(b);
      check(b - a == 6, "R3 os period", b - a, 6);
      wait_bit(t1);
      check(t1 - t2 == 78, "R4 bit period", t1 - t2, 78);
   endtask

   task automatic t_rewrite();
      int tp, t1, t2;
      wait_bit(tp);
      @(negedge clk);
      write_cfg(32'h0000_0004);
      write_cfg(32'h0002_0000);           // replaces: P=2, D=0 -> 3 clocks
      check(cfg_rdata == 32'h0002_0000, "R7 readback last", cfg_rdata, 32'h0002_0000);
      check(upd_busy == 1'b1, "R7 busy", upd_busy, 1);
      wait_bit(t1);
      check(t1 - tp == 78, "R5 old period kept", t1 - tp, 78);
      @(negedge clk);
      check(upd_busy == 1'b0, "R6 busy cleared", upd_busy, 0);
      wait_bit(t2);
      check(t2 - t1 == 39, "R7 last write wins", t2 - t1, 39);
   endtask

   task automatic t_align();
      int a, t, t2;
      a = cyc;
      rx_align = 1'b1;
      @(negedge clk);
      rx_align = 1'b0;
      wait_bit(t);
      check(t - a == 21, "R8 align to mid", t - a, 21);
      wait_bit(t2);
      check(t2 - t == 39, "R8 period after align", t2 - t, 39);
   endtask

   task automatic t_mask_max();
      int t, a, b;
      @(negedge clk);
      write_cfg(32'hFFF0_FC00);
      check(cfg_rdata == 32'h0, "R2 unused bits ignored", cfg_rdata, 0);
      write_cfg(32'hFFFF_FFFF);
      check(cfg_rdata == 32'h000F_03FF, "R2 mask", cfg_rdata, 32'h000F_03FF);
      wait_bit(t);
      @(negedge clk);
      check(upd_busy == 1'b0, "R6 busy cleared", upd_busy, 0);
      wait_os(a); wait_os(b);
      check(b - a == 16384, "R3 max os period", b - a, 16384);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_update();
      t_rewrite();
      t_align();
      t_mask_max();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait (cyc >= 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule